// File: doc/BRIEF.md
# UART Receiver with Pending-Byte Queue and Early RTS

This block receives 8N1 asynchronous serial frames on one input line and hands them to a consumer through a single visible data register. A six-slot queue sits behind that register, so bursts are absorbed while the consumer is slow. Reception is armed by a one-cycle start pulse and disarmed by a one-cycle stop pulse. While disarmed, the line is ignored.

Whenever the data register has been consumed and a byte is waiting, the oldest waiting byte is moved into the register and a one-cycle ready event is raised. With flow control on, an active-low request-to-send output is dropped well before the queue fills. A well-behaved sender therefore has room for four more bytes after seeing it drop. If a byte still arrives with every slot taken, it replaces the most recently queued byte and a sticky overflow flag is raised.

The bit period is set at run time by a divisor input. The divisor gives clock cycles per bit and must be at least 4.

Top module: `uart_rx_core`

## Requirements
- R1: Before a start pulse, and after reception has been stopped, frames on `rxd` produce no ready event and leave `rx_data` unchanged.
- R2: A frame has one low start bit, eight data bits sent least significant bit first, and one high stop bit. Each bit lasts `baud_div` clock cycles and is sampled near its centre.
- R3: When the data register holds no unconsumed byte and a byte is queued, that byte appears on `rx_data` and `rx_ready` is high for exactly that one cycle. At all other times `rx_data` holds its value.
- R4: A cycle with `rd_strobe` high consumes the current `rx_data`. If a byte is queued, it appears on `rx_data` with `rx_ready` high in the following cycle. If nothing is queued, no ready event follows and `rx_data` keeps its old value.
- R5: Up to six bytes can wait behind the data register. They are delivered in arrival order with none lost.
- R6: With `flow_en` high, `rts_n` is 1 while two or more bytes are queued (four or fewer free slots) and 0 otherwise. With `flow_en` low, `rts_n` is 0.
- R7: A byte that completes while six bytes are queued and none is being taken replaces the most recently queued byte. It also sets `overflow`, which stays 1 until reset.
- R8: A frame whose stop bit is sampled low is discarded. A low pulse shorter than half a bit period is not taken as a start bit.
- R9: A stop pulse during a frame lets that frame complete and be queued. Later frames are ignored, and queued bytes can still be read out.
- R10: After reset, `rx_ready`, `rx_data`, `rts_n` and `overflow` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_rx | input | 1 | One-cycle pulse that arms reception |
| stop_rx | input | 1 | One-cycle pulse that disarms reception after the current frame |
| rxd | input | 1 | Serial receive line, idle high |
| rd_strobe | input | 1 | Consumes the current data register byte |
| flow_en | input | 1 | Enables request-to-send throttling |
| baud_div | input | 16 | Clock cycles per bit (at least 4) |
| rx_data | output | 8 | Visible receive data register |
| rx_ready | output | 1 | One-cycle event: a new byte was moved into `rx_data` |
| rts_n | output | 1 | Active-low request to send |
| overflow | output | 1 | Sticky flag: a queued byte was overwritten |

## Verification
The bench fills all six slots behind an occupied data register and then sends one more byte. If the design replaced the wrong slot or dropped the byte, the delivered stream would differ from the model's. If it lost the sticky flag, `overflow` would read 0. It compares `rts_n` against the model's queue depth at each threshold crossing and with flow control off; an off-by-one threshold would drop the line one byte late or early. A bad stop bit, a short glitch, frames sent while disarmed, and a stop pulse in mid-frame are each followed by a count of ready events. A design that accepted any of these would show an extra event, and one that cut the frame short would lose the byte. A read with nothing queued must leave `rx_data` unchanged and raise no event.

// File: rtl/uart_rx_pkg.sv
// Shared types for the UART receive path.
// Assumes: nothing beyond IEEE 1800-2017.
package uart_rx_pkg;

    // Receive framer states
    typedef enum logic [2:0] {
        RX_OFF,
        RX_HUNT,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

endpackage

// File: rtl/uart_rx_sync.sv
// Two-flop synchronizer for the asynchronous serial input.
// Assumes: the line idles high, so both flops reset to 1.
module uart_rx_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic meta;

    // Retime the raw line through two flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= 1'b1;
            dout <= 1'b1;
        end else begin
            meta <= din;
            dout <= meta;
        end
    end
endmodule

// File: rtl/uart_rx_framer.sv
// Bit engine: hunts for a falling edge, confirms the start bit at half a bit,
// shifts in DATA_W bits LSB first at bit centres and checks the stop bit.
// Emits a one-cycle byte_valid only for frames with a high stop bit.
// Assumes: baud_div >= 4, and rxd_s is already synchronized.
module uart_rx_framer
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_rx,
    input  logic              stop_rx,
    input  logic              rxd_s,
    input  logic [DIV_W-1:0]  baud_div,
    output logic              byte_valid,
    output logic [DATA_W-1:0] byte_data,
    output logic              enabled
);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    rx_state_e         state;
    logic [DIV_W-1:0]  cnt;
    logic [IDX_W-1:0]  bit_idx;
    logic [DATA_W-1:0] shreg;
    logic              stop_req;
    logic              rxd_prev;
    logic [DIV_W-1:0]  half_m1;
    logic [DIV_W-1:0]  full_m1;
    logic              halt;

    assign half_m1   = (baud_div >> 1) - ONE;
    assign full_m1   = baud_div - ONE;
    assign halt      = stop_req | stop_rx;
    assign enabled   = (state != RX_OFF);
    assign byte_data = shreg;

    // Remember the previous line level for falling-edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) rxd_prev <= 1'b1;
        else        rxd_prev <= rxd_s;
    end

    // Frame state machine with bit timing, shifting and stop request handling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= RX_OFF;
            cnt        <= '0;
            bit_idx    <= '0;
            shreg      <= '0;
            stop_req   <= 1'b0;
            byte_valid <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            if (start_rx)     stop_req <= 1'b0;
            else if (stop_rx) stop_req <= 1'b1;
            case (state)
                RX_OFF: begin
                    if (start_rx) state <= RX_HUNT;
                end
                RX_HUNT: begin
                    if (halt && !start_rx) begin
                        state    <= RX_OFF;
                        stop_req <= 1'b0;
                    end else if (rxd_prev && !rxd_s) begin
                        state <= RX_START;
                        cnt   <= '0;
                    end
                end
                RX_START: begin
                    if (cnt == half_m1) begin
                        cnt     <= '0;
                        bit_idx <= '0;
                        if (!rxd_s) state <= RX_DATA;
                        else        state <= RX_HUNT;
                    end else begin
                        cnt <= cnt + ONE;
                    end
                end
                RX_DATA: begin
                    if (cnt == full_m1) begin
                        cnt   <= '0;
                        shreg <= {rxd_s, shreg[DATA_W-1:1]};
                        if (bit_idx == LAST_IDX) state <= RX_STOP;
                        else bit_idx <= bit_idx + 1'b1;
                    end else begin
                        cnt <= cnt + ONE;
                    end
                end
                RX_STOP: begin
                    if (cnt == full_m1) begin
                        cnt        <= '0;
                        byte_valid <= rxd_s;
                        if (halt && !start_rx) begin
                            state    <= RX_OFF;
                            stop_req <= 1'b0;
                        end else begin
                            state <= RX_HUNT;
                        end
                    end else begin
                        cnt <= cnt + ONE;
                    end
                end
                default: state <= RX_OFF;
            endcase
        end
    end
endmodule

// File: rtl/uart_rx_fifo_buf.sv
// Pending-byte queue of DEPTH entries (DEPTH need not be a power of two).
// A push while full with no pop rewrites the newest entry and flags ovf_evt.
// Assumes: the caller never pops an empty queue (such pops are ignored).
module uart_rx_fifo_buf #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 6,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [CNT_W-1:0] count,
    output logic             ovf_evt
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [WIDTH-1:0] slot [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr, newest, wr_idx;
    logic             full, pop_ok, push_ok, wr_en;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == FULL);
    assign pop_ok  = pop && (count != '0);
    assign push_ok = push && (!full || pop_ok);
    assign ovf_evt = push && full && !pop_ok;
    assign wr_en   = push_ok || ovf_evt;
    assign newest  = (wr_ptr == '0) ? LAST : wr_ptr - 1'b1;
    assign wr_idx  = ovf_evt ? newest : wr_ptr;
    assign rdata   = slot[rd_ptr];

    // Write the incoming byte into its slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
        end else if (wr_en) begin
            slot[wr_idx] <= wdata;
        end
    end

    // Advance pointers and track occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= step(wr_ptr);
            if (pop_ok)  rd_ptr <= step(rd_ptr);
            count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
        end
    end
endmodule

// File: rtl/uart_rx_core.sv
// UART receiver top: synchronizer, framer, pending queue and the visible
// data register with move-on-read and a one-cycle ready event.
// rts_n is dropped (driven 1) when free queue slots fall to RTS_FREE.
// Assumes: baud_div >= 4; RTS_FREE < DEPTH.
module uart_rx_core #(
    parameter int DATA_W   = 8,
    parameter int DIV_W    = 16,
    parameter int DEPTH    = 6,
    parameter int RTS_FREE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_rx,
    input  logic              stop_rx,
    input  logic              rxd,
    input  logic              rd_strobe,
    input  logic              flow_en,
    input  logic [DIV_W-1:0]  baud_div,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              rts_n,
    output logic              overflow
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] RTS_LEVEL = CNT_W'(DEPTH - RTS_FREE);

    logic              rxd_s;
    logic              rx_push;
    logic [DATA_W-1:0] rx_byte;
    logic              rx_enabled;
    logic              pop;
    logic [DATA_W-1:0] head;
    logic [CNT_W-1:0]  fifo_cnt;
    logic              ovf_evt;
    logic              held;

    uart_rx_sync u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rxd),
        .dout  (rxd_s)
    );

    uart_rx_framer #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_rx   (start_rx),
        .stop_rx    (stop_rx),
        .rxd_s      (rxd_s),
        .baud_div   (baud_div),
        .byte_valid (rx_push),
        .byte_data  (rx_byte),
        .enabled    (rx_enabled)
    );

    uart_rx_fifo_buf #(.WIDTH(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (rx_push),
        .wdata   (rx_byte),
        .pop     (pop),
        .rdata   (head),
        .count   (fifo_cnt),
        .ovf_evt (ovf_evt)
    );

    assign pop   = (fifo_cnt != '0) && (!held || rd_strobe);
    assign rts_n = flow_en && (fifo_cnt >= RTS_LEVEL);

    // Load the data register from the queue head and raise the ready event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data  <= '0;
            rx_ready <= 1'b0;
            held     <= 1'b0;
        end else begin
            rx_ready <= pop;
            if (pop) begin
                rx_data <= head;
                held    <= 1'b1;
            end else if (rd_strobe) begin
                held <= 1'b0;
            end
        end
    end

    // Sticky overwrite flag, cleared only by reset
    always_ff @(posedge clk) begin
        if (!rst_n)       overflow <= 1'b0;
        else if (ovf_evt) overflow <= 1'b1;
    end
endmodule

// File: rtl/uart_rx_core_chk.sv
// Temporal checks on the UART receiver, bound into every uart_rx_core.
// Assumes: reset is synchronous and active low.
module uart_rx_core_chk #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 6,
    parameter int CNT_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flow_en,
    input logic              rts_n,
    input logic              rx_ready,
    input logic [DATA_W-1:0] rx_data,
    input logic              overflow,
    input logic [CNT_W-1:0]  fifo_cnt,
    input logic              rx_enabled,
    input logic              rx_push
);
    AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CNT_W'(DEPTH)); // R5

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow); // R7

    AST_OVF_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> ($past(fifo_cnt) == CNT_W'(DEPTH))); // R7

    AST_PUSH_ONLY_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> $past(rx_enabled)); // R1

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_ready |-> $stable(rx_data)); // R3

    AST_READY_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> ($past(fifo_cnt) != '0)); // R4

    AST_RTS_NO_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !flow_en |-> !rts_n); // R6
endmodule

bind uart_rx_core uart_rx_core_chk #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .CNT_W  (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flow_en    (flow_en),
    .rts_n      (rts_n),
    .rx_ready   (rx_ready),
    .rx_data    (rx_data),
    .overflow   (overflow),
    .fifo_cnt   (fifo_cnt),
    .rx_enabled (rx_enabled),
    .rx_push    (rx_push)
);

// File: tb/uart_rx_core_tb_top.sv
// Self-checking bench: a behavioural queue model of the expected byte stream,
// compared against every ready event on every clock, plus checks at quiet points.
module uart_rx_core_tb_top;
    localparam int DIV = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_rx = 1'b0;
    logic       stop_rx = 1'b0;
    logic       rxd = 1'b1;
    logic       rd_strobe = 1'b0;
    logic       flow_en = 1'b0;
    logic [15:0] baud_div = 16'(DIV);
    logic [7:0] rx_data;
    logic       rx_ready;
    logic       rts_n;
    logic       overflow;

    int n_checks = 0;
    int n_fails  = 0;
    int n_ready  = 0;
    logic [7:0] exp_q [$];

    always #4 clk = ~clk;

    uart_rx_core dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_rx  (start_rx),
        .stop_rx   (stop_rx),
        .rxd       (rxd),
        .rd_strobe (rd_strobe),
        .flow_en   (flow_en),
        .baud_div  (baud_div),
        .rx_data   (rx_data),
        .rx_ready  (rx_ready),
        .rts_n     (rts_n),
        .overflow  (overflow)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Every ready event must deliver the next byte of the model stream (R3, R5)
    always @(negedge clk) begin
        if (rst_n && rx_ready) begin
            n_ready++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R1/R8 unexpected ready", rx_data, 0);
            end else begin
                check(rx_data == exp_q[0], "R5 stream order", rx_data, exp_q[0]);
                void'(exp_q.pop_front());
            end
        end
    end

    task automatic ticks(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send(input logic [7:0] b, input bit good_stop, input int stop_at);
        rxd = 1'b0;
        ticks(DIV);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            if (i == stop_at) begin
                stop_rx = 1'b1;
                ticks(1);
                stop_rx = 1'b0;
                ticks(DIV - 1);
            end else begin
                ticks(DIV);
            end
        end
        rxd = good_stop;
        ticks(DIV);
        rxd = 1'b1;
        ticks(2 * DIV);
    endtask

    task automatic read_once();
        rd_strobe = 1'b1;
        ticks(1);
        rd_strobe = 1'b0;
        ticks(3);
    endtask

    task automatic check_rts(input string req);
        int exp_r;
        exp_r = (flow_en && exp_q.size() >= 2) ? 1 : 0;
        check(rts_n == exp_r[0], req, rts_n, exp_r);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=0 expected=1");
        finish_run();
    end

    initial begin
        int seen;
        logic [7:0] d [8];
        ticks(4);
        @(negedge clk);
        // R10 reset state
        check(rx_ready == 1'b0, "R10 ready", rx_ready, 0);
        check(rx_data == 8'h00, "R10 data", rx_data, 0);
        check(rts_n == 1'b0, "R10 rts", rts_n, 0);
        check(overflow == 1'b0, "R10 overflow", overflow, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        flow_en = 1'b1;
        ticks(4);

        // R1: frame before start is ignored
        send(8'hF0, 1'b1, -1);
        check(n_ready == 0, "R1 no event before start", n_ready, 0);
        check(rx_data == 8'h00, "R1 data untouched", rx_data, 0);

        start_rx = 1'b1; ticks(1); start_rx = 1'b0; ticks(2);

        // R2/R3: first byte moves straight into the data register
        exp_q.push_back(8'hA5);
        send(8'hA5, 1'b1, -1);
        check(rx_data == 8'hA5, "R2 frame decode", rx_data, 8'hA5);
        check(n_ready == 1, "R3 single ready event", n_ready, 1);
        check_rts("R6 rts with empty queue");

        // R6: threshold crossing as bytes queue behind the register
        exp_q.push_back(8'h3C);
        send(8'h3C, 1'b1, -1);
        check_rts("R6 rts one queued");
        exp_q.push_back(8'h81);
        send(8'h81, 1'b1, -1);
        check_rts("R6 rts two queued");
        check(rts_n == 1'b1, "R6 rts dropped", rts_n, 1);

        // R4: reads move the next byte in
        read_once();
        check(rx_data == 8'h3C, "R4 read moves next", rx_data, 8'h3C);
        check_rts("R6 rts back after read");
        read_once();
        check(rx_data == 8'h81, "R4 second read", rx_data, 8'h81);
        seen = n_ready;
        read_once();
        check(n_ready == seen, "R4 empty read no event", n_ready, seen);
        check(rx_data == 8'h81, "R4 empty read keeps data", rx_data, 8'h81);

        // R5/R7: fill register plus six slots, then overflow
        for (int i = 0; i < 8; i++) d[i] = 8'(8'h10 + i * 8'h13);
        for (int i = 0; i < 6; i++) exp_q.push_back(d[i]);
        exp_q.push_back(d[7]);
        for (int i = 0; i < 7; i++) send(d[i], 1'b1, -1);
        check(rx_data == d[0], "R5 register holds first", rx_data, d[0]);
        check(overflow == 1'b0, "R5 six queued no overflow", overflow, 0);
        check_rts("R6 rts queue full");
        flow_en = 1'b0; ticks(1);
        check(rts_n == 1'b0, "R6 rts with flow off", rts_n, 0);
        flow_en = 1'b1; ticks(1);
        send(d[7], 1'b1, -1);
        check(overflow == 1'b1, "R7 overflow set", overflow, 1);
        for (int i = 0; i < 6; i++) read_once();
        check(rx_data == d[7], "R7 newest overwritten", rx_data, d[7]);
        check(exp_q.size() == 0, "R5 all delivered", exp_q.size(), 0);
        check(overflow == 1'b1, "R7 overflow sticky", overflow, 1);
        check_rts("R6 rts after drain");

        // R8: bad stop bit and short glitch
        seen = n_ready;
        send(8'h55, 1'b0, -1);
        rxd = 1'b0; ticks(4); rxd = 1'b1; ticks(3 * DIV);
        read_once();
        check(n_ready == seen, "R8 bad frames discarded", n_ready, seen);
        exp_q.push_back(8'h7E);
        send(8'h7E, 1'b1, -1);
        check(rx_data == 8'h7E, "R8 recovers after bad frames", rx_data, 8'h7E);

        // R9: stop mid-frame finishes that frame, later frames ignored
        read_once();
        exp_q.push_back(8'h12);
        exp_q.push_back(8'h34);
        send(8'h12, 1'b1, -1);
        send(8'h34, 1'b1, 3);
        seen = n_ready;
        send(8'h99, 1'b1, -1);
        check(n_ready == seen, "R9 frame after stop ignored", n_ready, seen);
        check(rx_data == 8'h12, "R9 register intact", rx_data, 8'h12);
        read_once();
        check(rx_data == 8'h34, "R9 in-flight frame kept", rx_data, 8'h34);
        check(exp_q.size() == 0, "R9 stream complete", exp_q.size(), 0);

        finish_run();
    end
endmodule